// File: doc/BRIEF.md
# Little-Endian Aligned Load/Store Lane Unit

This block connects a 32-bit processor datapath to a data memory that is one 32-bit word wide and byte addressed. On a store it turns the access size and the low address bits into a four-bit lane-enable mask. It also moves the store data into the lanes that the mask selects. On a load it takes the addressed bytes from the returned word, right-aligns them, and sign- or zero-extends them to 32 bits. The result is registered and is presented one clock later together with a valid strobe.

Byte order is little-endian: byte offset 0 of a word sits on data bits 7:0. Every access must be naturally aligned for its size. An access that is not aligned never reaches the memory as a write or a read, and the load destination is left alone. The unit raises an address-error pulse instead, which the surrounding pipeline uses to trap.

The memory is expected to return read data in the same cycle that the word address is presented, and the unit samples it at the end of that cycle.

Top module: `mem_lane_steer`

## Requirements
- R1: `mem_word_addr` always equals `req_addr[31:2]`, so consecutive words are four byte addresses apart.
- R2: `req_size` encodes 00 = byte, 01 = half-word, 10 = word and 11 = reserved. A half-word with `req_addr[0]`=1, a word with `req_addr[1:0]`≠0, or any reserved-size request is illegal. Each such request raises `addr_err` high for exactly the one cycle that follows it.
- R3: An illegal store keeps `mem_we` low and `mem_be` at 0000. `mem_be` is 0000 whenever `mem_we` is low.
- R4: An illegal load keeps `mem_re` low and gives no `ld_valid`. `ld_data` changes only after an accepted load, and holds its value otherwise.
- R5: A legal byte store asserts `mem_be` bit `req_addr[1:0]` only. Byte lane k of `mem_wdata` carries `req_wdata[7:0]` for the enabled lane.
- R6: A legal half-word store asserts `mem_be`=0011 at offset 0 or 1100 at offset 2, with `req_wdata[15:0]` placed little-endian in those lanes.
- R7: A legal word store asserts `mem_be`=1111 and drives `req_wdata` unchanged.
- R8: A legal load raises `ld_valid` for one cycle in the cycle after the request. `mem_re` is high during the request.
- R9: Byte and half-word loads take the bytes that start at lane `req_addr[1:0]` of `mem_rdata`. They sign-extend when `req_signed`=1 and zero-extend when it is 0.
- R10: A word load returns `mem_rdata` unchanged, whatever the value of `req_signed`.
- R11: While reset is held, and after it is released, `ld_valid`, `addr_err` and `ld_data` read zero until the first request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code |
| req_signed | input | 1 | Sign-extend sub-word loads |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| mem_rdata | input | 32 | Word returned by memory |
| mem_word_addr | output | 30 | Memory word index |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_be | output | 4 | Byte-lane write enables |
| mem_wdata | output | 32 | Lane-steered store data |
| ld_valid | output | 1 | Load result valid strobe |
| ld_data | output | 32 | Extended load result |
| addr_err | output | 1 | Misaligned or reserved access pulse |

## Verification
The bench covers every byte offset for each access size, so a mask shifted by one lane or a reversed byte order shows up as a wrong `mem_be` or wrong lane data. It loads bytes and half-words whose top bit is set, in both signed and unsigned form, which separates sign extension from zero extension and catches extension taken from the wrong bit. It also issues misaligned half-word and word accesses and reserved-size accesses. These expose a unit that still writes memory, still strobes `ld_valid`, or overwrites `ld_data` when it should report an address error. Word loads with the signed flag set confirm that the flag does not disturb full-width data.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    ACC_BYTE = 2'b00,
    ACC_HALF = 2'b01,
    ACC_WORD = 2'b10,
    ACC_RSVD = 2'b11
  } acc_size_e;
endpackage

// File: rtl/lsu_align_check.sv
module lsu_align_check
  import lsu_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  acc_size_e        size,
  input  logic [OFF_W-1:0] off,
  output logic             legal
);
  always_comb begin
    case (size)
      ACC_BYTE: legal = 1'b1;
      ACC_HALF: legal = ~off[0];
      ACC_WORD: legal = (off == '0);
      default:  legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  acc_size_e         size,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  lane_en,
  output logic [DATA_W-1:0] lane_data
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int HALF_SRC = i % 2;
    always_comb begin
      case (size)
        ACC_BYTE: begin
          lane_en[i]         = (int'(off) == i);
          lane_data[8*i +: 8] = wdata[7:0];
        end
        ACC_HALF: begin
          lane_en[i]         = ((int'(off) >> 1) == (i / 2));
          lane_data[8*i +: 8] = wdata[8*HALF_SRC +: 8];
        end
        ACC_WORD: begin
          lane_en[i]         = 1'b1;
          lane_data[8*i +: 8] = wdata[8*i +: 8];
        end
        default: begin
          lane_en[i]         = 1'b0;
          lane_data[8*i +: 8] = wdata[8*i +: 8];
        end
      endcase
    end
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  acc_size_e         size,
  input  logic              sign_ext,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] shifted;
  logic              fill;

  always_comb begin
    shifted = rdata >> {off, 3'b000};
    fill    = 1'b0;
    case (size)
      ACC_BYTE: begin
        fill   = sign_ext & shifted[7];
        result = {{(DATA_W-8){fill}}, shifted[7:0]};
      end
      ACC_HALF: begin
        fill   = sign_ext & shifted[15];
        result = {{(DATA_W-16){fill}}, shifted[15:0]};
      end
      default: result = rdata;
    endcase
  end
endmodule

// File: rtl/mem_lane_steer.sv
module mem_lane_steer
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int WADDR_W = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [1:0]         req_size,
  input  logic               req_signed,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic [WADDR_W-1:0] mem_word_addr,
  output logic               mem_we,
  output logic               mem_re,
  output logic [LANES-1:0]   mem_be,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic               ld_valid,
  output logic [DATA_W-1:0]  ld_data,
  output logic               addr_err
);
  acc_size_e         size;
  logic [OFF_W-1:0]  off;
  logic              legal;
  logic [LANES-1:0]  lane_en;
  logic [DATA_W-1:0] lane_data;
  logic [DATA_W-1:0] ext_data;
  logic              ld_accept, st_accept, err_now;
  logic              ld_valid_d, err_d;
  logic [DATA_W-1:0] ld_data_d;
  logic              ld_valid_q, err_q;
  logic [DATA_W-1:0] ld_data_q;

  assign size = acc_size_e'(req_size);
  assign off  = req_addr[OFF_W-1:0];

  lsu_align_check #(.OFF_W(OFF_W)) u_align (
    .size(size), .off(off), .legal(legal)
  );

  lsu_store_steer #(.DATA_W(DATA_W)) u_store (
    .size(size), .off(off), .wdata(req_wdata),
    .lane_en(lane_en), .lane_data(lane_data)
  );

  lsu_load_extract #(.DATA_W(DATA_W)) u_load (
    .size(size), .sign_ext(req_signed), .off(off),
    .rdata(mem_rdata), .result(ext_data)
  );

  always_comb begin
    ld_accept  = req_valid & ~req_write & legal;
    st_accept  = req_valid &  req_write & legal;
    err_now    = req_valid & ~legal;
    ld_valid_d = ld_accept;
    err_d      = err_now;
    ld_data_d  = ext_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_valid_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      ld_valid_q <= ld_valid_d;
      err_q      <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ld_data_q <= '0;
    else if (ld_accept) ld_data_q <= ld_data_d;
  end

  assign mem_word_addr = req_addr[ADDR_W-1:OFF_W];
  assign mem_we        = st_accept;
  assign mem_re        = ld_accept;
  assign mem_be        = st_accept ? lane_en : '0;
  assign mem_wdata     = lane_data;
  assign ld_valid      = ld_valid_q;
  assign ld_data       = ld_data_q;
  assign addr_err      = err_q;

  assert_store_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (req_size != 2'b11) && (req_size == 2'b00 || !req_addr[0]));
  assert_byte_one_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && req_size == 2'b00) |-> $countones(mem_be) == 1);
  assert_word_all_lanes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && req_size == 2'b10) |-> &mem_be);
  assert_rsvd_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'b11) |=> addr_err);
  assert_byte_load_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size == 2'b00) |=> ld_valid);
  assert_err_excludes_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_valid && addr_err));
  assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_re |=> $stable(ld_data));
endmodule

// File: tb/mem_lane_steer_test.sv
`timescale 1ns/1ps
module mem_lane_steer_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_signed;
  logic [1:0]  req_size;
  logic [31:0] req_addr, req_wdata, mem_rdata;
  logic [29:0] mem_word_addr;
  logic        mem_we, mem_re, ld_valid, addr_err;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, ld_data;

  always #4 clk = ~clk;

  mem_lane_steer uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_signed(req_signed), .req_addr(req_addr),
    .req_wdata(req_wdata), .mem_rdata(mem_rdata), .mem_word_addr(mem_word_addr),
    .mem_we(mem_we), .mem_re(mem_re), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .ld_valid(ld_valid), .ld_data(ld_data), .addr_err(addr_err)
  );

  logic [31:0] bmem [16];
  logic [31:0] rmem [16];
  assign mem_rdata = bmem[mem_word_addr[3:0]];

  always @(posedge clk)
    if (mem_we)
      for (int i = 0; i < 4; i++)
        if (mem_be[i]) bmem[mem_word_addr[3:0]][8*i +: 8] <= mem_wdata[8*i +: 8];

  int    vectors = 0;
  int    errors  = 0;
  bit    done    = 0;
  logic        exp_lv, exp_err;
  logic [31:0] exp_ld;
  string       ld_tag, lv_tag;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit v, bit w, logic [1:0] sz, bit sg, logic [31:0] addr, logic [31:0] wd);
    int bytes, off;
    bit legal, ewe, ere;
    logic [3:0]  ebe;
    logic [31:0] val;
    string stag;
    @(negedge clk);
    chk(lv_tag, {31'd0, ld_valid}, {31'd0, exp_lv});
    chk("R2", {31'd0, addr_err}, {31'd0, exp_err});
    chk(ld_tag, ld_data, exp_ld);
    req_valid = v; req_write = w; req_size = sz; req_signed = sg;
    req_addr = addr; req_wdata = wd;
    #1;
    bytes = 1 << sz;
    off   = int'(addr[1:0]);
    legal = (sz != 2'b11) && (off % bytes == 0);
    ewe   = v && w && legal;
    ere   = v && !w && legal;
    stag  = !legal ? "R3" : (sz == 0) ? "R5" : (sz == 1) ? "R6" : "R7";
    ebe   = '0;
    if (ewe) for (int i = 0; i < 4; i++) ebe[i] = (i >= off) && (i < off + bytes);
    chk("R1", {2'b00, mem_word_addr}, {2'b00, addr[31:2]});
    chk(stag, {31'd0, mem_we}, {31'd0, ewe});
    chk(legal ? "R8" : "R4", {31'd0, mem_re}, {31'd0, ere});
    chk(stag, {28'd0, mem_be}, {28'd0, ebe});
    if (ewe)
      for (int i = 0; i < 4; i++)
        if (ebe[i]) chk(stag, {24'd0, mem_wdata[8*i +: 8]}, {24'd0, wd[8*(i-off) +: 8]});
    exp_err = v && !legal;
    exp_lv  = ere;
    lv_tag  = (v && !w && !legal) ? "R4" : "R8";
    ld_tag  = (v && !w && !legal) ? "R4" : "R8";
    if (ere) begin
      val = rmem[addr[5:2]] >> (8*off);
      if (sz == 2'b00) begin
        val &= 32'h0000_00ff;
        if (sg && val[7]) val |= 32'hffff_ff00;
        ld_tag = "R9";
      end else if (sz == 2'b01) begin
        val &= 32'h0000_ffff;
        if (sg && val[15]) val |= 32'hffff_0000;
        ld_tag = "R9";
      end else ld_tag = "R10";
      exp_ld = val;
    end
    if (ewe)
      for (int i = 0; i < 4; i++)
        if (ebe[i]) rmem[addr[5:2]][8*i +: 8] = wd[8*(i-off) +: 8];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      bmem[i] = 32'h80f1_7f82 ^ (i * 32'h1357_9bdf);
      rmem[i] = bmem[i];
    end
    rst_n = 1'b0;
    req_valid = 0; req_write = 0; req_size = 0; req_signed = 0;
    req_addr = 0; req_wdata = 0;
    exp_lv = 0; exp_err = 0; exp_ld = 0; lv_tag = "R11"; ld_tag = "R11";
    repeat (3) @(negedge clk);
    chk("R11", {31'd0, ld_valid}, 32'd0);
    chk("R11", {31'd0, addr_err}, 32'd0);
    chk("R11", ld_data, 32'd0);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0);
    lv_tag = "R8"; ld_tag = "R4";
    for (int o = 0; o < 4; o++) step(1, 1, 2'b00, 0, 32'h1000_0010 + o, 32'h0000_00a0 + o);
    step(1, 1, 2'b01, 0, 32'h2000_0020, 32'h0000_8c01);
    step(1, 1, 2'b01, 0, 32'h2000_0022, 32'h0000_fe77);
    step(1, 1, 2'b10, 0, 32'h3000_0024, 32'h8765_4321);
    step(1, 1, 2'b01, 0, 32'h2000_0021, 32'h0000_dead);
    step(1, 1, 2'b10, 0, 32'h3000_0026, 32'hdead_beef);
    step(1, 1, 2'b11, 0, 32'h3000_0028, 32'h1111_1111);
    for (int o = 0; o < 4; o++) begin
      step(1, 0, 2'b00, 1, 32'h1000_0010 + o, 0);
      step(1, 0, 2'b00, 0, 32'h1000_0010 + o, 0);
    end
    step(1, 0, 2'b01, 1, 32'h2000_0020, 0);
    step(1, 0, 2'b01, 0, 32'h2000_0020, 0);
    step(1, 0, 2'b01, 1, 32'h2000_0022, 0);
    step(1, 0, 2'b10, 1, 32'h3000_0024, 0);
    step(1, 0, 2'b01, 1, 32'h2000_0023, 0);
    step(1, 0, 2'b10, 0, 32'h3000_0025, 0);
    step(1, 0, 2'b11, 1, 32'h3000_0024, 0);
    step(0, 0, 2'b00, 0, 32'h3000_0024, 0);
    for (int n = 0; n < 600; n++)
      step(($urandom_range(0, 9) != 0), $urandom_range(0, 1), 2'($urandom_range(0, 3)),
           $urandom_range(0, 1), $urandom(), $urandom());
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule